// File: doc/BRIEF.md
# Converter Controller Register Bank

This block is the software-visible register bank of a sixteen-channel analog-to-digital converter controller. It sits on a simple 32-bit word bus with address, read strobe, write strobe, write data and read data. It holds these registers:

- engine control, with an enable bit, a mode field and per-channel enables
- an interrupt-source word and a comparator-trim word
- three general control words: interrupt, detect and clock
- eight data words, each carrying two 10-bit channel results
- sixteen limit words and sixteen hysteresis words

Each register keeps only the bits it owns. Engine control has two write side effects: its init-done bit copies the written enable bit, and its auto-compensation bit is always stored as zero. Read data is registered and stays stable between read strobes. The converter itself and its clocking are outside this block.

Top module: `adc_regfile`

## Requirements
- R1: After synchronous reset every register reads 0, except detect control (0x08) and clock control (0x0C), which read 0x0000000F.
- R2: A write to engine control (0x00) stores bit 8 equal to the written bit 0, whatever value was written to bit 8.
- R3: A write to engine control always stores bit 5 as 0. All other bits (31:9, 7:6, 4:0) are stored as written.
- R4: Interrupt control (0x04), detect control (0x08) and clock control (0x0C) store and return all 32 bits.
- R5: The eight data words at 0x10 to 0x2C keep bits 25:16 and 9:0 (mask 0x03FF03FF). All other bits read 0.
- R6: The sixteen limit words at 0x30 to 0x6C use the same 0x03FF03FF mask.
- R7: The sixteen hysteresis words at 0x70 to 0xAC keep bit 31 and the two 10-bit fields (mask 0x83FF03FF).
- R8: Interrupt source (0xC0) keeps bits 15:0. Comparator trim (0xC4) keeps bits 3:0.
- R9: A read of any unmapped word offset returns 0. A write to one leaves every mapped register unchanged.
- R10: Read data appears on the clock edge that samples the read strobe and holds until the next read strobe. Address bits 1:0 are ignored, so the word index within an array is (address minus array base) shifted right by 2.
- R11: When a read and a write to the same register happen in the same cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (12) | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
Writes take effect on the clock edge that samples the write strobe. Read data is registered on the edge that samples the read strobe, so it is valid one cycle after the strobe is driven. The bench drives every access on a falling edge and samples the read data on the next falling edge, which lies after the capturing rising edge and before any later one. The hold behaviour is checked on that falling edge and on later idle cycles, and also across a write that has no read beside it. A read and a write issued together are compared with the model value taken before that write is applied.

// File: rtl/adc_regs_pkg.sv
package adc_regs_pkg;

  localparam int DATA_W = 32;

  // word offsets of the single registers
  localparam int unsigned OFS_ENGINE = 32'h000;
  localparam int unsigned OFS_IRQCTL = 32'h004;
  localparam int unsigned OFS_DETECT = 32'h008;
  localparam int unsigned OFS_CLKCTL = 32'h00C;
  localparam int unsigned OFS_IRQSRC = 32'h0C0;
  localparam int unsigned OFS_TRIM   = 32'h0C4;

  // engine control bits with write side effects
  localparam int ENG_EN_BIT    = 0;
  localparam int ENG_ACOMP_BIT = 5;
  localparam int ENG_INIT_BIT  = 8;

  localparam logic [DATA_W-1:0] RST_DETECT = 32'h0000_000F;
  localparam logic [DATA_W-1:0] RST_CLKCTL = 32'h0000_000F;
  localparam logic [DATA_W-1:0] MASK_IRQSRC = 32'h0000_FFFF;
  localparam logic [DATA_W-1:0] MASK_TRIM   = 32'h0000_000F;

  // word arrays: data pairs, limits, hysteresis
  localparam int NUM_ARR = 3;
  localparam int unsigned ARR_BASE  [NUM_ARR] = '{32'h010, 32'h030, 32'h070};
  localparam int unsigned ARR_WORDS [NUM_ARR] = '{8, 16, 16};
  localparam logic [DATA_W-1:0] ARR_MASK [NUM_ARR] =
    '{32'h03FF_03FF, 32'h03FF_03FF, 32'h83FF_03FF};

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_SCALAR = 2'd1,
    RD_ARRAY  = 2'd2
  } rd_src_e;

endpackage

// File: rtl/adc_ctrl_bank.sv
module adc_ctrl_bank
  import adc_regs_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              hit,
  output logic [DATA_W-1:0] rdata
);

  localparam int WA_W = ADDR_W - 2;

  logic [WA_W-1:0]   wa;
  logic [DATA_W-1:0] eng_q, irqc_q, det_q, clkc_q, src_q, trim_q;
  logic [DATA_W-1:0] eng_d;
  logic sel_eng, sel_irqc, sel_det, sel_clkc, sel_src, sel_trim;

  assign wa       = WA_W'(addr >> 2);
  assign sel_eng  = (wa == WA_W'(OFS_ENGINE >> 2));
  assign sel_irqc = (wa == WA_W'(OFS_IRQCTL >> 2));
  assign sel_det  = (wa == WA_W'(OFS_DETECT >> 2));
  assign sel_clkc = (wa == WA_W'(OFS_CLKCTL >> 2));
  assign sel_src  = (wa == WA_W'(OFS_IRQSRC >> 2));
  assign sel_trim = (wa == WA_W'(OFS_TRIM >> 2));
  assign hit = sel_eng | sel_irqc | sel_det | sel_clkc | sel_src | sel_trim;

  // engine control: init-done follows enable, auto-compensation never sticks
  always_comb begin
    eng_d                = wdata;
    eng_d[ENG_INIT_BIT]  = wdata[ENG_EN_BIT];
    eng_d[ENG_ACOMP_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eng_q  <= '0;
      irqc_q <= '0;
      det_q  <= RST_DETECT;
      clkc_q <= RST_CLKCTL;
      src_q  <= '0;
      trim_q <= '0;
    end else if (wr) begin
      if (sel_eng)  eng_q  <= eng_d;
      if (sel_irqc) irqc_q <= wdata;
      if (sel_det)  det_q  <= wdata;
      if (sel_clkc) clkc_q <= wdata;
      if (sel_src)  src_q  <= wdata & MASK_IRQSRC;
      if (sel_trim) trim_q <= wdata & MASK_TRIM;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel_eng)  rdata = eng_q;
    if (sel_irqc) rdata = irqc_q;
    if (sel_det)  rdata = det_q;
    if (sel_clkc) rdata = clkc_q;
    if (sel_src)  rdata = src_q;
    if (sel_trim) rdata = trim_q;
  end

  assert_init_follows_en_R2: assert property (@(posedge clk) disable iff (rst)
    (wr && sel_eng) |=> (eng_q[ENG_INIT_BIT] == $past(wdata[ENG_EN_BIT])));

  assert_acomp_cleared_R3: assert property (@(posedge clk) disable iff (rst)
    (wr && sel_eng) |=> (eng_q[ENG_ACOMP_BIT] == 1'b0));

  assert_narrow_masks_R8: assert property (@(posedge clk) disable iff (rst)
    ((src_q & ~MASK_IRQSRC) == '0) && ((trim_q & ~MASK_TRIM) == '0));

endmodule

// File: rtl/adc_word_array.sv
module adc_word_array
  import adc_regs_pkg::*;
#(
  parameter int ADDR_W                   = 12,
  parameter int unsigned BASE            = 32'h010,
  parameter int unsigned WORDS           = 8,
  parameter logic [DATA_W-1:0] KEEP_MASK = 32'h03FF_03FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  output logic              hit,
  output logic [DATA_W-1:0] rdata_q
);

  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [ADDR_W-1:0] off, off_w;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] mem [WORDS];

  assign off   = addr - ADDR_W'(BASE);
  assign off_w = off >> 2;
  assign hit   = (addr >= ADDR_W'(BASE)) && (off_w < ADDR_W'(WORDS));
  assign idx   = off_w[IDX_W-1:0];

  // storage; the read port returns the word held before a same-cycle write
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(WORDS); i++) mem[i] <= '0;
      rdata_q <= '0;
    end else begin
      if (wr && hit) mem[idx] <= wdata & KEEP_MASK;
      if (rd && hit) rdata_q  <= mem[idx];
    end
  end

  // one label per use: data words R5, limits R6, hysteresis R7
  assert_field_mask_R5: assert property (@(posedge clk) disable iff (rst)
    (rdata_q & ~KEEP_MASK) == '0);

  assert_port_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !(rd && hit) |=> $stable(rdata_q));

endmodule

// File: rtl/adc_regfile.sv
module adc_regfile
  import adc_regs_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);

  localparam int ASEL_W = $clog2(NUM_ARR);

  logic              ctl_hit;
  logic [DATA_W-1:0] ctl_rdata;
  logic [NUM_ARR-1:0] arr_hit;
  logic [DATA_W-1:0] arr_q [NUM_ARR];
  logic              any_hit;
  logic [ASEL_W-1:0] arr_pick;

  rd_src_e           src_q;
  logic [ASEL_W-1:0] arr_sel_q;
  logic [DATA_W-1:0] scal_q;

  adc_ctrl_bank #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .addr  (bus_addr),
    .wr    (bus_wr),
    .wdata (bus_wdata),
    .hit   (ctl_hit),
    .rdata (ctl_rdata)
  );

  for (genvar g = 0; g < NUM_ARR; g++) begin : g_arr
    adc_word_array #(
      .ADDR_W    (ADDR_W),
      .BASE      (ARR_BASE[g]),
      .WORDS     (ARR_WORDS[g]),
      .KEEP_MASK (ARR_MASK[g])
    ) u_arr (
      .clk     (clk),
      .rst     (rst),
      .addr    (bus_addr),
      .wr      (bus_wr),
      .rd      (bus_rd),
      .wdata   (bus_wdata),
      .hit     (arr_hit[g]),
      .rdata_q (arr_q[g])
    );
  end

  assign any_hit = ctl_hit | (|arr_hit);

  always_comb begin
    arr_pick = '0;
    for (int i = 0; i < NUM_ARR; i++)
      if (arr_hit[i]) arr_pick = ASEL_W'(i);
  end

  // remember which source the last read targeted
  always_ff @(posedge clk) begin
    if (rst) begin
      src_q     <= RD_NONE;
      arr_sel_q <= '0;
      scal_q    <= '0;
    end else if (bus_rd) begin
      scal_q    <= ctl_rdata;
      arr_sel_q <= arr_pick;
      if (ctl_hit)       src_q <= RD_SCALAR;
      else if (|arr_hit) src_q <= RD_ARRAY;
      else               src_q <= RD_NONE;
    end
  end

  always_comb begin
    case (src_q)
      RD_SCALAR: bus_rdata = scal_q;
      RD_ARRAY:  bus_rdata = arr_q[arr_sel_q];
      default:   bus_rdata = '0;
    endcase
  end

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !any_hit) |=> (bus_rdata == '0));

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  assert_acomp_reads_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && ((bus_addr >> 2) == '0)) |=> !bus_rdata[ENG_ACOMP_BIT]);

  assert_single_target_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl_hit, arr_hit}));

endmodule

// File: tb/test_adc_regfile.sv
module test_adc_regfile;

  logic        clk = 1'b0;
  logic        rst;
  logic [11:0] bus_addr;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_eng, m_irqc, m_det, m_clkc, m_src, m_trim;
  logic [31:0] m_chan [8];
  logic [31:0] m_lim  [16];
  logic [31:0] m_hys  [16];

  always #5 clk = ~clk;

  adc_regfile i_adc_regfile (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    int w = int'(a) >> 2;
    if (w == 0)  return m_eng;
    if (w == 1)  return m_irqc;
    if (w == 2)  return m_det;
    if (w == 3)  return m_clkc;
    if (w >= 4  && w < 12) return m_chan[w-4];
    if (w >= 12 && w < 28) return m_lim[w-12];
    if (w >= 28 && w < 44) return m_hys[w-28];
    if (w == 48) return m_src;
    if (w == 49) return m_trim;
    return 32'h0;
  endfunction

  task automatic model_reset();
    m_eng = 0; m_irqc = 0; m_det = 32'hF; m_clkc = 32'hF; m_src = 0; m_trim = 0;
    for (int i = 0; i < 8; i++)  m_chan[i] = 0;
    for (int i = 0; i < 16; i++) begin m_lim[i] = 0; m_hys[i] = 0; end
  endtask

  task automatic model_write(input logic [11:0] a, input logic [31:0] d);
    int w = int'(a) >> 2;
    logic [31:0] e;
    if (w == 0) begin
      e = d; e[8] = d[0]; e[5] = 1'b0; m_eng = e;
    end
    else if (w == 1) m_irqc = d;
    else if (w == 2) m_det = d;
    else if (w == 3) m_clkc = d;
    else if (w >= 4  && w < 12) m_chan[w-4]  = d & 32'h03FF_03FF;
    else if (w >= 12 && w < 28) m_lim[w-12]  = d & 32'h03FF_03FF;
    else if (w >= 28 && w < 44) m_hys[w-28]  = d & 32'h83FF_03FF;
    else if (w == 48) m_src  = d & 32'h0000_FFFF;
    else if (w == 49) m_trim = d & 32'h0000_000F;
  endtask

  function automatic string req_of(input logic [11:0] a);
    int w = int'(a) >> 2;
    if (w == 0) return "R2/R3";
    if (w >= 1 && w <= 3) return "R4";
    if (w >= 4 && w < 12) return "R5";
    if (w >= 12 && w < 28) return "R6";
    if (w >= 28 && w < 44) return "R7";
    if (w == 48 || w == 49) return "R8";
    return "R9";
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  // one bus cycle; returns read data sampled on the following falling edge
  task automatic bus_op(input logic do_rd, input logic do_wr, input logic [11:0] a,
                        input logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    bus_addr = a; bus_rd = do_rd; bus_wr = do_wr; bus_wdata = d;
    @(negedge clk);
    q = bus_rdata;
    bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] q;
    bus_op(1'b0, 1'b1, a, d, q);
    model_write(a, d);
  endtask

  task automatic rd_check(input string req, input logic [11:0] a);
    logic [31:0] q;
    bus_op(1'b1, 1'b0, a, 32'h0, q);
    check(req, q, exp_read(a));
  endtask

  task automatic sweep(input string req);
    for (int w = 0; w < 52; w++) rd_check(req, 12'(w * 4));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] q, held;
    logic [11:0] a;
    logic [31:0] d;
    int op;
    rst = 1'b1; bus_addr = '0; bus_rd = 0; bus_wr = 0; bus_wdata = '0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    check("R1 rdata after reset", bus_rdata, 32'h0);

    // R1: reset values of every mapped word
    sweep("R1");

    // R2 / R3: engine control side effects
    wr_reg(12'h000, 32'hFFFF_FFFE);
    rd_check("R2 init cleared by en=0", 12'h000);
    check("R3 engine literal", exp_read(12'h000), 32'hFFFF_FEDE);
    wr_reg(12'h000, 32'h0000_0021);
    rd_check("R2 init set by en=1", 12'h000);
    check("R2 engine literal", exp_read(12'h000), 32'h0000_0101);

    // R4: full-width scalar words
    wr_reg(12'h004, 32'hDEAD_BEEF); rd_check("R4 irqctl", 12'h004);
    wr_reg(12'h008, 32'hFFFF_FFFF); rd_check("R4 detect", 12'h008);
    wr_reg(12'h00C, 32'h1234_5678); rd_check("R4 clkctl", 12'h00C);

    // R5..R8: masks at the array edges
    wr_reg(12'h010, 32'hFFFF_FFFF); rd_check("R5 first data", 12'h010);
    wr_reg(12'h02C, 32'hFFFF_FFFF); rd_check("R5 last data", 12'h02C);
    wr_reg(12'h06C, 32'hFFFF_FFFF); rd_check("R6 last limit", 12'h06C);
    wr_reg(12'h070, 32'hFFFF_FFFF); rd_check("R7 first hyst", 12'h070);
    check("R7 hyst literal", exp_read(12'h070), 32'h83FF_03FF);
    wr_reg(12'h0C0, 32'hFFFF_FFFF); rd_check("R8 irqsrc", 12'h0C0);
    wr_reg(12'h0C4, 32'hFFFF_FFFF); rd_check("R8 trim", 12'h0C4);

    // R9: unmapped words read 0, writes to them change nothing
    wr_reg(12'h0B0, 32'hFFFF_FFFF);
    wr_reg(12'h0C8, 32'hFFFF_FFFF);
    wr_reg(12'hFFC, 32'hFFFF_FFFF);
    rd_check("R9 gap", 12'h0B0);
    rd_check("R9 top", 12'hFFC);
    sweep("R9 after unmapped writes");

    // R10: low address bits ignored, data held between strobes
    wr_reg(12'h02F, 32'h0155_02AA); rd_check("R10 low bits", 12'h02D);
    bus_op(1'b1, 1'b0, 12'h004, 32'h0, q);
    held = q;
    @(negedge clk); check("R10 hold idle", bus_rdata, held);
    wr_reg(12'h004, 32'h0BAD_F00D);
    check("R10 hold across write", bus_rdata, held);

    // R11: same-cycle read and write returns the old value
    d = 32'hA5A5_5A5A;
    held = exp_read(12'h034);
    bus_op(1'b1, 1'b1, 12'h034, d, q);
    model_write(12'h034, d);
    check("R11 array old value", q, held);
    held = exp_read(12'h00C);
    bus_op(1'b1, 1'b1, 12'h00C, d, q);
    model_write(12'h00C, d);
    check("R11 scalar old value", q, held);
    rd_check("R11 new value", 12'h00C);

    // random mix of reads and writes
    void'($urandom(32'h00C0_FFEE));
    for (int n = 0; n < 3000; n++) begin
      op = int'($urandom_range(0, 9));
      a = (op == 9) ? 12'($urandom_range(0, 12'hFFF)) : 12'($urandom_range(0, 12'h0CF));
      d = $urandom();
      if (op < 4) begin
        wr_reg(a, d);
      end else if (op < 6) begin
        held = exp_read(a);
        bus_op(1'b1, 1'b1, a, d, q);
        model_write(a, d);
        check({req_of(a), " R11 random"}, q, held);
      end else begin
        rd_check({req_of(a), " random"}, a);
      end
    end

    // reset again restores defaults
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    model_reset();
    sweep("R1 re-reset");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule